// File: doc/BRIEF.md
# History-Indexed Indirect Jump Target Predictor

This block guesses where an indirect jump will go. It uses the path that led to the jump, as well as the jump's own address. A global history register holds the directions of recent branches. A small target cache is addressed by the XOR of that history with the word-aligned fetch address. When a lookup is marked as an indirect jump, the cached target becomes the prediction. For any other control transfer, the target that arrives from the branch target buffer passes through unchanged.

A build-time parameter selects one of two organisations. The tagless form has one way and no tags, so every indirect lookup returns whatever its entry holds. The tagged form has two ways per set. Each way keeps a tag taken from the upper address bits, and a target is used only when that tag matches. A miss falls back to the buffer target and lowers the hit flag. Each set has one bit that remembers which way was used least recently.

Results are registered and appear one cycle after the lookup. The lookup also returns the history it used, so the pipeline can hand that history back on the update port once the real target is known.

Top module: `itc_target_cache`

## Requirements
- R1: In the cycle after reset is released, the history register is zero, no result is valid and every tagged entry is invalid. Tagless targets read as zero with the hit flag set.
- R2: When `hist_valid` is high, the history shifts left by one bit and `hist_taken` enters at bit 0 (1 = taken, 0 = not taken). Otherwise it holds. `out_hist` returns the history that was in force on the lookup's cycle.
- R3: The set index is `lk_pc[HIST_W+1:2] XOR history`, so one address under different histories reads different entries.
- R4: A lookup with `lk_indirect` low returns `lk_btb_tgt` with `out_hit` low, even if a cached entry would match.
- R5: In tagged mode, an indirect lookup whose set holds a valid way with tag `lk_pc[PC_W-1:HIST_W+2]` returns that way's target with `out_hit` high.
- R6: In tagged mode, an indirect lookup with no matching valid way returns `lk_btb_tgt` with `out_hit` low.
- R7: An update writes `upd_tgt` into the set `upd_pc[HIST_W+1:2] XOR upd_hist`. The current history plays no part, and in tagged mode the tag is stored and the way marked valid.
- R8: A tagged update rewrites the way whose valid tag already matches. If no way matches, it fills an invalid way, choosing way 0 first. Only when both ways are valid does it evict the least recently used way.
- R9: A tagged lookup hit or an update write makes that way the most recently used in its set. A refresh from a lookup hit on the cycle just before an update to the same set is honoured by that update.
- R10: In tagless mode, every indirect lookup has `out_hit` high and returns the entry at its index. Entries alias across addresses with no tag check.
- R11: The result appears exactly one cycle after `lk_valid`. An update in the same cycle as a lookup is not visible to that lookup, but it is visible to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Address of the control-transfer instruction |
| lk_indirect | input | 1 | Instruction is an indirect jump |
| lk_btb_tgt | input | PC_W | Target supplied by the branch target buffer |
| out_valid | output | 1 | Result valid, one cycle after lk_valid |
| out_tgt | output | PC_W | Predicted target |
| out_hit | output | 1 | Target came from the cache |
| out_hist | output | HIST_W | History used by the lookup |
| upd_valid | input | 1 | Write an actual target |
| upd_pc | input | PC_W | Address of the resolved jump |
| upd_tgt | input | PC_W | Actual target |
| upd_hist | input | HIST_W | History captured at lookup |
| hist_valid | input | 1 | Shift a branch outcome into the history |
| hist_taken | input | 1 | Outcome: 1 taken, 0 not taken |

## Verification
The assertions are checked on every cycle. They cover the one-cycle result timing, the history shift and hold, the history snapshot returned with each result, the pass-through for non-indirect lookups, the rule that a miss always carries the buffer target, and the tagless hit flag. Some behaviour depends on stored contents, and only the bench scenarios can show it. That includes hashed indexing under changing history, writes steered by the captured history rather than the live one, aliasing in tagless mode, tag rejection, victim choice among matching, invalid and least-recently-used ways, and read-before-write ordering within a cycle.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef enum logic {
    ITC_TAGLESS = 1'b0,
    ITC_TAGGED  = 1'b1
  } itc_mode_e;
endpackage

// File: rtl/itc_ghr.sv
module itc_ghr #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              taken,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], taken};
  end
endmodule

// File: rtl/itc_way.sv
module itc_way #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 8,
  parameter int TAG_W     = 22,
  parameter bit CLEAR_TGT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_match,
  output logic [PC_W-1:0]  rd_tgt,
  input  logic [IDX_W-1:0] pr_idx,
  output logic             pr_valid,
  output logic [TAG_W-1:0] pr_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt
);
  localparam int SETS = 1 << IDX_W;

  logic [PC_W-1:0]  tgt_mem [SETS];
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  vld;

  assign pr_valid = vld[pr_idx];
  assign pr_tag   = tag_mem[pr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      rd_match <= 1'b0;
    end else begin
      if (rd_en) rd_match <= vld[rd_idx] && (tag_mem[rd_idx] == rd_tag);
      if (wr_en) vld[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  generate
    if (CLEAR_TGT) begin : g_clr
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < SETS; s++) tgt_mem[s] <= '0;
          rd_tgt <= '0;
        end else begin
          if (wr_en) tgt_mem[wr_idx] <= wr_tgt;
          if (rd_en) rd_tgt <= tgt_mem[rd_idx];
        end
      end
    end else begin : g_ram
      always_ff @(posedge clk) begin
        if (wr_en) tgt_mem[wr_idx] <= wr_tgt;
        if (rd_en) rd_tgt <= tgt_mem[rd_idx];
      end
    end
  endgenerate
endmodule

// File: rtl/itc_target_cache.sv
module itc_target_cache
  import itc_pkg::*;
#(
  parameter int        PC_W   = 32,
  parameter int        HIST_W = 8,
  parameter itc_mode_e MODE   = ITC_TAGGED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic              lk_indirect,
  input  logic [PC_W-1:0]   lk_btb_tgt,
  output logic              out_valid,
  output logic [PC_W-1:0]   out_tgt,
  output logic              out_hit,
  output logic [HIST_W-1:0] out_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [PC_W-1:0]   upd_tgt,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              hist_valid,
  input  logic              hist_taken
);
  localparam int TAG_W = PC_W - 2 - HIST_W;
  localparam int WAYS  = (MODE == ITC_TAGGED) ? 2 : 1;
  localparam int SETS  = 1 << HIST_W;

  logic [HIST_W-1:0] ghr;
  logic [HIST_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;

  itc_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk(clk), .rst(rst), .shift_en(hist_valid), .taken(hist_taken), .hist(ghr)
  );

  assign lk_idx = lk_pc[2 +: HIST_W] ^ ghr;
  assign up_idx = upd_pc[2 +: HIST_W] ^ upd_hist;
  assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
  assign up_tag = upd_pc[PC_W-1 -: TAG_W];

  logic              v_q, ind_q;
  logic [PC_W-1:0]   btb_q;
  logic [HIST_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q      <= 1'b0;
      ind_q    <= 1'b0;
      btb_q    <= '0;
      idx_q    <= '0;
      out_hist <= '0;
    end else begin
      v_q <= lk_valid;
      if (lk_valid) begin
        ind_q    <= lk_indirect;
        btb_q    <= lk_btb_tgt;
        idx_q    <= lk_idx;
        out_hist <= ghr;
      end
    end
  end

  logic [WAYS-1:0] way_match, way_pv, way_wr;
  logic [PC_W-1:0]  way_tgt [WAYS];
  logic [TAG_W-1:0] way_ptag [WAYS];
  logic             any_match;
  logic [PC_W-1:0]  sel_tgt;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      itc_way #(
        .PC_W(PC_W), .IDX_W(HIST_W), .TAG_W(TAG_W),
        .CLEAR_TGT(MODE == ITC_TAGLESS)
      ) u_way (
        .clk(clk), .rst(rst),
        .rd_en(lk_valid), .rd_idx(lk_idx), .rd_tag(lk_tag),
        .rd_match(way_match[w]), .rd_tgt(way_tgt[w]),
        .pr_idx(up_idx), .pr_valid(way_pv[w]), .pr_tag(way_ptag[w]),
        .wr_en(way_wr[w]), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(upd_tgt)
      );
    end

    if (WAYS == 2) begin : g_assoc
      logic [SETS-1:0] lru;
      logic            pr_m0, pr_m1, refresh, lru_eff, victim, hit_way;

      assign pr_m0   = way_pv[0] && (way_ptag[0] == up_tag);
      assign pr_m1   = way_pv[1] && (way_ptag[1] == up_tag);
      assign hit_way = !way_match[0];
      assign refresh = v_q && ind_q && (|way_match);
      assign lru_eff = (refresh && idx_q == up_idx) ? !hit_way : lru[up_idx];

      always_comb begin
        if (pr_m0)           victim = 1'b0;
        else if (pr_m1)      victim = 1'b1;
        else if (!way_pv[0]) victim = 1'b0;
        else if (!way_pv[1]) victim = 1'b1;
        else                 victim = lru_eff;
      end

      assign way_wr[0] = upd_valid && !victim;
      assign way_wr[1] = upd_valid && victim;
      assign any_match = |way_match;
      assign sel_tgt   = way_match[0] ? way_tgt[0] : way_tgt[1];

      always_ff @(posedge clk) begin
        if (rst) begin
          lru <= '0;
        end else begin
          if (refresh && !(upd_valid && idx_q == up_idx)) lru[idx_q] <= !hit_way;
          if (upd_valid) lru[up_idx] <= !victim;
        end
      end
    end else begin : g_direct
      assign way_wr[0] = upd_valid;
      assign any_match = 1'b1;
      assign sel_tgt   = way_tgt[0];
    end
  endgenerate

  assign out_valid = v_q;
  assign out_hit   = ind_q && any_match;
  assign out_tgt   = out_hit ? sel_tgt : btb_q;
endmodule

// File: rtl/itc_target_cache_chk.sv
module itc_target_cache_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter bit TAGGED = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              lk_indirect,
  input logic [PC_W-1:0]   lk_btb_tgt,
  input logic              hist_valid,
  input logic              hist_taken,
  input logic [HIST_W-1:0] ghr,
  input logic              out_valid,
  input logic              out_hit,
  input logic [PC_W-1:0]   out_tgt,
  input logic [HIST_W-1:0] out_hist
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (ghr == '0 && !out_valid));

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    hist_valid |=> ghr == {$past(ghr[HIST_W-2:0]), $past(hist_taken)});

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !hist_valid |=> $stable(ghr));

  assert_snap_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> out_hist == $past(ghr));

  assert_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_indirect) |=> (!out_hit && out_tgt == $past(lk_btb_tgt)));

  assert_miss_R6: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (out_hit || out_tgt == $past(lk_btb_tgt)));

  assert_lat_R11: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> out_valid);

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !out_valid);

  generate
    if (!TAGGED) begin : g_tl
      assert_tagless_R10: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_indirect) |=> out_hit);
    end
  endgenerate
endmodule

bind itc_target_cache itc_target_cache_chk #(
  .PC_W(PC_W), .HIST_W(HIST_W), .TAGGED(WAYS == 2)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_indirect(lk_indirect),
  .lk_btb_tgt(lk_btb_tgt), .hist_valid(hist_valid), .hist_taken(hist_taken),
  .ghr(ghr), .out_valid(out_valid), .out_hit(out_hit), .out_tgt(out_tgt),
  .out_hist(out_hist)
);

// File: tb/itc_target_cache_tb.sv
`timescale 1ns/1ps
module itc_target_cache_tb;
  import itc_pkg::*;
  localparam int PW = 32;
  localparam int HW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0, lk_indirect = 0, upd_valid = 0, hist_valid = 0, hist_taken = 0;
  logic [PW-1:0] lk_pc = '0, lk_btb_tgt = '0, upd_pc = '0, upd_tgt = '0;
  logic [HW-1:0] upd_hist = '0;

  logic t_valid, t_hit, u_valid, u_hit;
  logic [PW-1:0] t_tgt, u_tgt;
  logic [HW-1:0] t_hist, u_hist;

  always #2 clk = ~clk;

  itc_target_cache #(.PC_W(PW), .HIST_W(HW), .MODE(ITC_TAGGED)) u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .lk_indirect(lk_indirect), .lk_btb_tgt(lk_btb_tgt),
    .out_valid(t_valid), .out_tgt(t_tgt), .out_hit(t_hit), .out_hist(t_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_tgt(upd_tgt), .upd_hist(upd_hist),
    .hist_valid(hist_valid), .hist_taken(hist_taken)
  );

  itc_target_cache #(.PC_W(PW), .HIST_W(HW), .MODE(ITC_TAGLESS)) u_dut_tl (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .lk_indirect(lk_indirect), .lk_btb_tgt(lk_btb_tgt),
    .out_valid(u_valid), .out_tgt(u_tgt), .out_hit(u_hit), .out_hist(u_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_tgt(upd_tgt), .upd_hist(upd_hist),
    .hist_valid(hist_valid), .hist_taken(hist_taken)
  );

  typedef struct packed { logic [PW-1:0] tgt; logic hit; logic [HW-1:0] hist; } exp_t;
  exp_t  q_t[$], q_u[$];
  string r_t[$], r_u[$];
  int n_chk = 0, n_fail = 0;
  logic [HW-1:0] ghr_m = '0;

  localparam logic [PW-1:0] PA = 32'h0000_0104; // index bits 1, tag 4
  localparam logic [PW-1:0] PB = 32'h0000_0044; // index bits 1, tag 1
  localparam logic [PW-1:0] PC = 32'h0000_0084; // index bits 1, tag 2

  task automatic compare(input string side, input string r, input exp_t e,
                         input logic [PW-1:0] tg, input logic h, input logic [HW-1:0] hs);
    n_chk++;
    if (tg !== e.tgt || h !== e.hit || hs !== e.hist) begin
      n_fail++;
      $display("FAIL %s %s: got tgt=%h hit=%b hist=%h exp tgt=%h hit=%b hist=%h",
               r, side, tg, h, hs, e.tgt, e.hit, e.hist);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (t_valid) begin
        if (q_t.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R11 tagged: got unexpected result exp none");
        end else compare("tagged", r_t.pop_front(), q_t.pop_front(), t_tgt, t_hit, t_hist);
      end
      if (u_valid) begin
        if (q_u.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R11 tagless: got unexpected result exp none");
        end else compare("tagless", r_u.pop_front(), q_u.pop_front(), u_tgt, u_hit, u_hist);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    lk_valid = 0; upd_valid = 0; hist_valid = 0;
  endtask

  task automatic look(input logic [PW-1:0] pc, input logic ind, input logic [PW-1:0] btb,
                      input logic [PW-1:0] et, input logic eh,
                      input logic [PW-1:0] ut, input logic uh, input string r);
    lk_valid = 1; lk_pc = pc; lk_indirect = ind; lk_btb_tgt = btb;
    q_t.push_back('{tgt: et, hit: eh, hist: ghr_m}); r_t.push_back(r);
    q_u.push_back('{tgt: ut, hit: uh, hist: ghr_m}); r_u.push_back(r);
  endtask

  task automatic upd(input logic [PW-1:0] pc, input logic [HW-1:0] h, input logic [PW-1:0] tg);
    upd_valid = 1; upd_pc = pc; upd_hist = h; upd_tgt = tg;
  endtask

  task automatic shift(input logic tk);
    hist_valid = 1; hist_taken = tk;
    step();
    ghr_m = {ghr_m[HW-2:0], tk};
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got no finish exp finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    n_chk++;
    if (t_valid !== 1'b0 || u_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got valid=%b/%b exp 0/0", t_valid, u_valid);
    end
    @(posedge clk); #1;
    // R1 / R6: empty tagged cache misses; tagless reads cleared zero
    look(PA, 1, 32'hBBBB_0001, 32'hBBBB_0001, 0, 32'h0, 1, "R1 R6"); step();
    // R4: non-indirect passes buffer target
    look(32'h200, 0, 32'hBBBB_0002, 32'hBBBB_0002, 0, 32'hBBBB_0002, 0, "R4"); step();
    // R5: write then hit
    upd(PA, 4'h0, 32'h1111_0000); step();
    look(PA, 1, 32'hBBBB_0003, 32'h1111_0000, 1, 32'h1111_0000, 1, "R5"); step();
    // R2 R3: history 0110 moves index to 7
    shift(1); shift(1); shift(0);
    look(PA, 1, 32'hBBBB_0004, 32'hBBBB_0004, 0, 32'h0, 1, "R2 R3"); step();
    upd(PA, 4'h6, 32'h2222_0000); step();
    look(PA, 1, 32'hBBBB_0005, 32'h2222_0000, 1, 32'h2222_0000, 1, "R3"); step();
    // R10: alias with a different tag; R6 tag rejection
    look(PB, 1, 32'hBBBB_0006, 32'hBBBB_0006, 0, 32'h2222_0000, 1, "R10"); step();
    // R7: update indexed by supplied history, not the live one
    upd(PB, 4'h0, 32'h3333_0000); step();
    shift(0); shift(0); shift(0); shift(0);
    look(PA, 1, 32'hBBBB_0007, 32'h1111_0000, 1, 32'h3333_0000, 1, "R7"); step();
    look(PB, 1, 32'hBBBB_0008, 32'h3333_0000, 1, 32'h3333_0000, 1, "R8"); step();
    // R9: refresh A, then fill evicts B
    look(PA, 1, 32'hBBBB_0009, 32'h1111_0000, 1, 32'h3333_0000, 1, "R9"); step();
    upd(PC, 4'h0, 32'h4444_0000); step();
    look(PB, 1, 32'hBBBB_000A, 32'hBBBB_000A, 0, 32'h4444_0000, 1, "R9"); step();
    look(PA, 1, 32'hBBBB_000B, 32'h1111_0000, 1, 32'h4444_0000, 1, "R9"); step();
    look(PC, 1, 32'hBBBB_000C, 32'h4444_0000, 1, 32'h4444_0000, 1, "R9"); step();
    // R8: tag match rewrites its own way even when LRU points elsewhere
    look(PA, 1, 32'hBBBB_000D, 32'h1111_0000, 1, 32'h4444_0000, 1, "R8"); step();
    upd(PA, 4'h0, 32'h5555_0000); step();
    look(PC, 1, 32'hBBBB_000E, 32'h4444_0000, 1, 32'h5555_0000, 1, "R8"); step();
    look(PA, 1, 32'hBBBB_000F, 32'h5555_0000, 1, 32'h5555_0000, 1, "R8"); step();
    // R11: same-cycle update invisible to that lookup
    look(PA, 1, 32'hBBBB_0010, 32'h5555_0000, 1, 32'h5555_0000, 1, "R11");
    upd(PA, 4'h0, 32'h6666_0000); step();
    look(PA, 1, 32'hBBBB_0011, 32'h6666_0000, 1, 32'h6666_0000, 1, "R11"); step();
    // R4: cached address, non-indirect
    look(PA, 0, 32'hBBBB_0012, 32'hBBBB_0012, 0, 32'hBBBB_0012, 0, "R4"); step();
    repeat (3) step();
    n_chk++;
    if (q_t.size() != 0 || q_u.size() != 0) begin
      n_fail++;
      $display("FAIL R11: got pending=%0d/%0d exp 0/0", q_t.size(), q_u.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule